// File: doc/BRIEF.md
# Condition Field Compare Generator

This block turns one compare request into a 4-bit condition field and the index of the field slot that should receive it. Two kinds of compare are supported: a general compare of a 32-bit operand against either a second 32-bit operand or a 16-bit immediate, interpreted as signed or unsigned, and a record-form update that compares an arithmetic result against zero. The produced field holds, from its most significant bit down, a less-than flag, a greater-than flag, an equal flag and a copy of the summary overflow flag.

For the general compare, the immediate is sign-extended when the compare is signed and zero-extended when it is unsigned. The destination slot comes from the request when it carries one; otherwise slot 0 is used. A record-form update always compares signed against zero and always targets slot 0, whatever the signedness and destination inputs say. Its summary-overflow bit is the value after the same instruction's overflow update, i.e. the incoming summary flag ORed with the instruction's own overflow.

The result is registered. A two-state machine tracks whether a write is being presented. ST_IDLE moves to ST_WRITE on the transition "accept" (a valid request with a legal mode). ST_WRITE stays in ST_WRITE on "accept" and returns to ST_IDLE on "drain" (no valid request, or the reserved mode). The write strobe is high exactly in ST_WRITE. The condition storage and the operand reads sit outside this block.

Top module: `cmpf_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wr_en` is 0.
- R2: A request with `req_valid`=1 and a legal mode is presented one clock later with `wr_en`=1. A cycle without a valid request gives `wr_en`=0 in the next cycle.
- R3: Register compare (mode 0) with `req_signed`=1 orders `opa` and `opb` as 32-bit two's complement numbers.
- R4: Register compare with `req_signed`=0 orders `opa` and `opb` as 32-bit unsigned numbers.
- R5: Immediate compare (mode 1) with `req_signed`=1 compares `opa` with `imm` sign-extended to 32 bits, signed.
- R6: Immediate compare with `req_signed`=0 compares `opa` with `imm` zero-extended to 32 bits, unsigned.
- R7: In modes 0 and 1, bit 0 of `wr_value` (the summary-overflow bit) equals `so_in` as sampled with the request.
- R8: In modes 0 and 1, `wr_field` is `req_dest` when `req_has_dest`=1, and 0 otherwise.
- R9: Record-form (mode 2) compares `opa` with zero as signed, ignoring `req_signed`, and writes slot 0, ignoring `req_has_dest` and `req_dest`.
- R10: In record-form, bit 0 of `wr_value` is `so_in | ov_in`.
- R11: When `wr_en`=1, exactly one of `wr_value[3]` (less), `wr_value[2]` (greater) and `wr_value[1]` (equal) is 1.
- R12: Mode 3 is reserved. A valid request in mode 3 produces `wr_en`=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 2 | 0 register, 1 immediate, 2 record-form, 3 reserved |
| req_signed | input | 1 | 1 for a signed compare (modes 0 and 1) |
| req_has_dest | input | 1 | Request names a destination slot |
| req_dest | input | 3 | Destination slot index |
| opa | input | 32 | First operand, or the arithmetic result in record-form |
| opb | input | 32 | Second operand for register compare |
| imm | input | 16 | Immediate for immediate compare |
| so_in | input | 1 | Current summary overflow flag |
| ov_in | input | 1 | Overflow of this instruction (record-form) |
| wr_en | output | 1 | Field write strobe |
| wr_field | output | 3 | Destination slot index |
| wr_value | output | 4 | {less, greater, equal, summary overflow} |

## Verification
The embedded assertions check on every cycle the relation between an accepted request and the write strobe one cycle later, the suppression for the reserved mode, the one-hot relation bits, the slot-0 target and OR-ed summary bit of record-form, and the summary bit copied from the previous cycle for the ordinary compares. Only the bench scenarios can show that the ordering is correct: signed against unsigned results for the same bit patterns, sign- against zero-extension of a negative-looking immediate, record-form ignoring the signedness and destination inputs, and the default slot when no destination is given.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;
    typedef enum logic [1:0] {
        MODE_REG  = 2'd0,
        MODE_IMM  = 2'd1,
        MODE_REC  = 2'd2,
        MODE_RSVD = 2'd3
    } cmp_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } wr_state_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_field_t;
endpackage

// File: rtl/cmpf_operand_sel.sv
module cmpf_operand_sel
    import cmpf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  cmp_mode_e          mode,
    input  logic               req_signed,
    input  logic [DATA_W-1:0]  opb,
    input  logic [IMM_W-1:0]   imm,
    output logic [DATA_W-1:0]  b_eff,
    output logic               signed_eff
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sext;
    logic [DATA_W-1:0] imm_zext;

    assign imm_sext = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign imm_zext = {{EXT_W{1'b0}}, imm};

    always_comb begin
        unique case (mode)
            MODE_IMM: begin
                b_eff      = req_signed ? imm_sext : imm_zext;
                signed_eff = req_signed;
            end
            MODE_REC: begin
                b_eff      = '0;
                signed_eff = 1'b1;
            end
            default: begin
                b_eff      = opb;
                signed_eff = req_signed;
            end
        endcase
    end
endmodule

// File: rtl/cmpf_relation.sv
module cmpf_relation #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              signed_cmp,
    output logic              lt,
    output logic              gt,
    output logic              eq
);
    logic [DATA_W-1:0] a_biased;
    logic [DATA_W-1:0] b_biased;

    // flipping the sign bit maps signed order onto unsigned order
    assign a_biased = {a[DATA_W-1] ^ signed_cmp, a[DATA_W-2:0]};
    assign b_biased = {b[DATA_W-1] ^ signed_cmp, b[DATA_W-2:0]};

    always_comb begin
        eq = (a == b);
        lt = (a_biased < b_biased);
        gt = !eq && !lt;
    end
endmodule

// File: rtl/cmpf_gen.sv
module cmpf_gen
    import cmpf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_mode,
    input  logic              req_signed,
    input  logic              req_has_dest,
    input  logic [IDX_W-1:0]  req_dest,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [IMM_W-1:0]  imm,
    input  logic              so_in,
    input  logic              ov_in,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_field,
    output logic [3:0]        wr_value
);
    localparam logic [IDX_W-1:0] DEFAULT_IDX = '0;

    cmp_mode_e         mode;
    wr_state_e         state_q, state_d;
    logic              accept;
    logic [DATA_W-1:0] b_eff;
    logic              signed_eff;
    logic              rel_lt, rel_gt, rel_eq;
    cond_field_t       field_d, field_q;
    logic [IDX_W-1:0]  idx_d, idx_q;

    assign mode   = cmp_mode_e'(req_mode);
    assign accept = req_valid && (mode != MODE_RSVD);

    cmpf_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
        .mode       (mode),
        .req_signed (req_signed),
        .opb        (opb),
        .imm        (imm),
        .b_eff      (b_eff),
        .signed_eff (signed_eff)
    );

    cmpf_relation #(.DATA_W(DATA_W)) u_rel (
        .a          (opa),
        .b          (b_eff),
        .signed_cmp (signed_eff),
        .lt         (rel_lt),
        .gt         (rel_gt),
        .eq         (rel_eq)
    );

    always_comb begin
        field_d.lt = rel_lt;
        field_d.gt = rel_gt;
        field_d.eq = rel_eq;
        if (mode == MODE_REC) begin
            field_d.so = so_in | ov_in;
            idx_d      = DEFAULT_IDX;
        end else begin
            field_d.so = so_in;
            idx_d      = req_has_dest ? req_dest : DEFAULT_IDX;
        end
    end

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = accept ? ST_WRITE : ST_IDLE;
            ST_WRITE: state_d = accept ? ST_WRITE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= '0;
            idx_q   <= '0;
        end else if (accept) begin
            field_q <= field_d;
            idx_q   <= idx_d;
        end
    end

    assign wr_en    = (state_q == ST_WRITE);
    assign wr_field = idx_q;
    assign wr_value = field_q;

    // R2
    wr_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> wr_en);

    // R12
    rsvd_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == MODE_RSVD) |=> !wr_en);

    // R11
    rel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $countones(wr_value[3:1]) == 1);

    // R9
    rec_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode == MODE_REC) |=> (wr_field == DEFAULT_IDX));

    // R10
    rec_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode == MODE_REC) |=> (wr_value[0] == $past(so_in | ov_in)));

    // R7
    cmp_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode != MODE_REC) |=> (wr_value[0] == $past(so_in)));
endmodule

// File: tb/cmpf_gen_test.sv
module cmpf_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_mode = 2'd0;
    logic        req_signed = 1'b0;
    logic        req_has_dest = 1'b0;
    logic [2:0]  req_dest = 3'd0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [15:0] imm = '0;
    logic        so_in = 1'b0;
    logic        ov_in = 1'b0;
    logic        wr_en;
    logic [2:0]  wr_field;
    logic [3:0]  wr_value;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cmpf_gen uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_signed(req_signed), .req_has_dest(req_has_dest), .req_dest(req_dest),
        .opa(opa), .opb(opb), .imm(imm), .so_in(so_in), .ov_in(ov_in),
        .wr_en(wr_en), .wr_field(wr_field), .wr_value(wr_value)
    );

    function automatic logic [2:0] rel3(input logic [31:0] a, input logic [31:0] b,
                                        input logic sgn);
        if (sgn) begin
            if ($signed(a) < $signed(b)) return 3'b100;
            if ($signed(a) > $signed(b)) return 3'b010;
        end else begin
            if (a < b) return 3'b100;
            if (a > b) return 3'b010;
        end
        return 3'b001;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] m, input logic s, input logic hd,
                        input logic [2:0] d, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] i, input logic so, input logic ov);
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_signed = s; req_has_dest = hd;
        req_dest = d; opa = a; opb = b; imm = i; so_in = so; ov_in = ov;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // compare a register / immediate request; checks strobe, slot and value
    task automatic run_cmp(input string req, input logic [1:0] m, input logic s,
                           input logic hd, input logic [2:0] d, input logic [31:0] a,
                           input logic [31:0] b, input logic [15:0] i, input logic so);
        logic [31:0] be;
        be = (m == 2'd1) ? (s ? {{16{i[15]}}, i} : {16'h0, i}) : b;
        send(m, s, hd, d, a, be === b ? b : b, i, so, 1'b0);
        check({req, " strobe"}, {7'd0, wr_en}, 8'd1);
        check({req, " slot"}, {5'd0, wr_field}, {5'd0, hd ? d : 3'd0});
        check({req, " value"}, {4'd0, wr_value}, {4'd0, rel3(a, be, s), so});
    endtask

    task automatic t_reset;
        check("R1 in reset", {7'd0, wr_en}, 8'd0);
        @(negedge clk); rst_n = 1'b1;
        check("R1 after reset", {7'd0, wr_en}, 8'd0);
    endtask

    task automatic t_signed_reg;
        run_cmp("R3 neg<pos", 2'd0, 1'b1, 1'b1, 3'd3, 32'hFFFF_FFF0, 32'd5, 16'h0, 1'b0);
        run_cmp("R3 pos>neg", 2'd0, 1'b1, 1'b1, 3'd6, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 1'b1);
        run_cmp("R3 equal", 2'd0, 1'b1, 1'b1, 3'd7, 32'h8000_0000, 32'h8000_0000, 16'h0, 1'b0);
    endtask

    task automatic t_unsigned_reg;
        run_cmp("R4 big>small", 2'd0, 1'b0, 1'b1, 3'd2, 32'hFFFF_FFF0, 32'd5, 16'h0, 1'b0);
        run_cmp("R4 small<big", 2'd0, 1'b0, 1'b1, 3'd1, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 1'b0);
    endtask

    task automatic t_imm;
        run_cmp("R5 sext eq", 2'd1, 1'b1, 1'b1, 3'd4, 32'hFFFF_8000, 32'h0, 16'h8000, 1'b0);
        run_cmp("R5 sext gt", 2'd1, 1'b1, 1'b1, 3'd4, 32'd0, 32'h0, 16'hFFFF, 1'b0);
        run_cmp("R6 zext lt", 2'd1, 1'b0, 1'b1, 3'd5, 32'hFFFF_8000 & 32'h0000_7FFF, 32'h0, 16'h8000, 1'b0);
        run_cmp("R6 zext gt", 2'd1, 1'b0, 1'b1, 3'd5, 32'hFFFF_8000, 32'h0, 16'h8000, 1'b1);
    endtask

    task automatic t_so_and_dest;
        run_cmp("R7 so copy", 2'd0, 1'b0, 1'b1, 3'd2, 32'd9, 32'd9, 16'h0, 1'b1);
        run_cmp("R8 default slot", 2'd0, 1'b1, 1'b0, 3'd5, 32'd1, 32'd2, 16'h0, 1'b0);
    endtask

    task automatic t_record;
        // unsigned flag and a destination given: both must be ignored
        send(2'd2, 1'b0, 1'b1, 3'd6, 32'h8000_0001, 32'h0, 16'h0, 1'b0, 1'b0);
        check("R9 rec neg slot", {5'd0, wr_field}, 8'd0);
        check("R9 rec neg value", {4'd0, wr_value}, {4'd0, 4'b1000});
        send(2'd2, 1'b1, 1'b0, 3'd0, 32'd0, 32'hFFFF, 16'h0, 1'b0, 1'b1);
        check("R10 rec ov sets so", {4'd0, wr_value}, {4'd0, 4'b0011});
        send(2'd2, 1'b1, 1'b1, 3'd1, 32'd7, 32'h0, 16'h0, 1'b1, 1'b0);
        check("R10 rec so kept", {4'd0, wr_value}, {4'd0, 4'b0101});
        check("R9 rec pos slot", {5'd0, wr_field}, 8'd0);
        check("R11 onehot", {7'd0, ^wr_value[3:1] & ~&wr_value[3:1]}, 8'd1);
    endtask

    task automatic t_idle_and_rsvd;
        @(negedge clk);
        check("R2 idle drops strobe", {7'd0, wr_en}, 8'd0);
        send(2'd3, 1'b1, 1'b1, 3'd4, 32'd1, 32'd2, 16'h0, 1'b1, 1'b1);
        check("R12 reserved no write", {7'd0, wr_en}, 8'd0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        req_valid = 1'b1; req_mode = 2'd0; req_signed = 1'b1; req_has_dest = 1'b1;
        req_dest = 3'd1; opa = 32'd3; opb = 32'd4; so_in = 1'b0; ov_in = 1'b0;
        @(negedge clk);
        check("R2 b2b first", {wr_en, wr_field, wr_value}, {1'b1, 3'd1, 4'b1000});
        req_dest = 3'd2; opa = 32'd4; opb = 32'd3;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 b2b second", {wr_en, wr_field, wr_value}, {1'b1, 3'd2, 4'b0100});
        @(negedge clk);
        check("R2 b2b drained", {7'd0, wr_en}, 8'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_signed_reg();
        t_unsigned_reg();
        t_imm();
        t_so_and_dest();
        t_record();
        t_idle_and_rsvd();
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule